// File: doc/BRIEF.md
# ISA Bus Target Decoder

This block is the slave-side front end of a PC/AT-style (PC/104) expansion-bus target. It samples the system address lines SA[19:0], the latched high address LA[23:17], the address-enable line AEN and the six active-low command strobes on every bus clock. From these it decodes one I/O window and one memory window. All bus-facing responses are drive enables for open-drain pins: the 16-bit I/O and 16-bit memory size indications, the cycle-extension line (pulled low to stretch a cycle) and the zero-wait termination line. An enable of 1 means "pull the pin low" and 0 means "release". No output ever drives a high level.

Toward the local logic the block gives a one-clock select pulse at the start of each decoded read or write, plus a read-data drive enable. It accepts a ready input from the local logic. When the local side is not ready as an access starts, the block stretches the bus cycle. The stretch lasts until the local ready arrives or a programmable wait budget runs out, whichever comes first. A memory window marked zero-wait terminates its cycles early instead and never stretches them.

Every output is registered: a response appears one clock after the bus inputs that cause it are sampled.

Top module: `isa_target_decoder`

## Requirements
- R1: While reset is asserted, every output is 0, whatever the bus inputs are.
- R2: An I/O access is decoded when (SA[15:0] & 16'hFFF0) == 16'h0300 and AEN is low. The access starts on the first clock that ior_n or iow_n is sampled low. It gives exactly one clock of io_rd_pulse or io_wr_pulse. With AEN high, or an address outside the window, no pulse is given.
- R3: iocs16_pull is 1 one clock after SA[15:0] falls in the I/O window while AEN is low. It does not depend on any strobe.
- R4: memcs16_pull is 1 one clock after LA[23:17] == 7'h06. It does not depend on SA, AEN or any strobe.
- R5: memr_n and memw_n select the memory window only when LA[23:17] == 7'h06 and SA[19:16] == 4'hD. smemr_n and smemw_n select it when SA[19:16] == 4'hD, with LA ignored. Each memory access gives one clock of mem_rd_pulse or mem_wr_pulse.
- R6: If loc_ready is 0 when a non-zero-wait access starts and wait_limit = N > 0, chrdy_pull is 1 from the start clock. It stays 1 for at most N clocks.
- R7: chrdy_pull falls one clock after loc_ready is sampled 1 during an extension. It is not raised again within the same access.
- R8: With wait_limit = 0, chrdy_pull stays 0 for every access.
- R9: For a memr_n or memw_n access to the memory window with AEN low (the zero-wait window), zws_pull is 1 for exactly the first clock of the access. chrdy_pull stays 0 whatever loc_ready is.
- R10: zws_pull is never 1 for an I/O access, an smemr_n/smemw_n access, or a memory access with AEN high. Those accesses take the normal wait path of R6.
- R11: zws_pull and chrdy_pull are never 1 in the same clock.
- R12: dbus_oe is 1 in each clock after a decoded read strobe is sampled low. It falls in the clock after that strobe is sampled high. It is never 1 for a write.
- R13: If the strobe ends during an extension, chrdy_pull falls in the next clock. A new strobe after that starts a fresh access with a new select pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sa | input | 20 | System address SA[19:0] |
| bus_la | input | 7 | Latched high address LA[23:17] |
| bus_aen | input | 1 | Address enable, high during DMA |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| smemr_n | input | 1 | Low-megabyte memory read strobe, active low |
| smemw_n | input | 1 | Low-megabyte memory write strobe, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| loc_ready | input | 1 | Local logic ready for the current access |
| wait_limit | input | 4 | Maximum extension in bus clocks (0 to 15) |
| iocs16_pull | output | 1 | Pull-low enable for the 16-bit I/O indication |
| memcs16_pull | output | 1 | Pull-low enable for the 16-bit memory indication |
| chrdy_pull | output | 1 | Pull-low enable for the cycle-extension line |
| zws_pull | output | 1 | Pull-low enable for the zero-wait termination line |
| dbus_oe | output | 1 | Read-data drive enable |
| io_rd_pulse | output | 1 | One-clock select at the start of an I/O read |
| io_wr_pulse | output | 1 | One-clock select at the start of an I/O write |
| mem_rd_pulse | output | 1 | One-clock select at the start of a memory read |
| mem_wr_pulse | output | 1 | One-clock select at the start of a memory write |

## Verification
A wrong ready state shows at the pins in the clock after it occurs. A counter that loads or decrements wrongly makes chrdy_pull last one clock too long or too short. A state that fails to return to idle either swallows the select pulse of the next strobe or raises the extension again within one access. A misrouted strobe or a lost AEN term shows up as a pulse on the wrong select line, or as a zws_pull on a cycle that must not terminate early. The checks compare all nine outputs on every clock, so any such fault is caught in the cycle it first appears.

// File: rtl/isa_tgt_pkg.sv
package isa_tgt_pkg;

    // Classified bus access, produced by the address decoder
    typedef struct packed {
        logic rd_io;
        logic wr_io;
        logic rd_mem;
        logic wr_mem;
        logic zw_ok;    // access qualifies for early termination
    } bus_access_t;

    typedef enum logic [1:0] {
        RDY_IDLE,
        RDY_WAIT,
        RDY_HOLD
    } rdy_state_e;

endpackage

// File: rtl/isa_addr_match.sv
module isa_addr_match
    import isa_tgt_pkg::*;
#(
    parameter logic [15:0] IO_BASE   = 16'h0300,
    parameter logic [15:0] IO_MASK   = 16'hFFF0,
    parameter bit          IO_WIDE   = 1'b1,
    parameter logic [23:0] MEM_BASE  = 24'h0D0000,
    parameter logic [23:0] MEM_MASK  = 24'hFF0000,
    parameter bit          MEM_WIDE  = 1'b1,
    parameter bit          ZERO_WAIT = 1'b1
) (
    input  logic [19:0] bus_sa,
    input  logic [6:0]  bus_la,
    input  logic        bus_aen,
    input  logic        ior_n,
    input  logic        iow_n,
    input  logic        smemr_n,
    input  logic        smemw_n,
    input  logic        memr_n,
    input  logic        memw_n,
    output logic        io_wide_hit,
    output logic        mem_wide_hit,
    output bus_access_t acc
);

    localparam logic [6:0]  LA_BASE    = MEM_BASE[23:17];
    localparam logic [6:0]  LA_MASK    = MEM_MASK[23:17];
    localparam logic [19:0] SA_BASE    = MEM_BASE[19:0];
    localparam logic [19:0] SA_MASK    = MEM_MASK[19:0];
    localparam bit          IN_LOW_1MB = (MEM_BASE[23:20] == 4'h0);

    logic io_hit, la_hit, sa_hit, full_hit, low_hit;

    always_comb begin
        io_hit   = ((bus_sa[15:0] & IO_MASK) == (IO_BASE & IO_MASK)) && !bus_aen;
        la_hit   = ((bus_la & LA_MASK) == (LA_BASE & LA_MASK));
        sa_hit   = ((bus_sa & SA_MASK) == (SA_BASE & SA_MASK));
        full_hit = la_hit && sa_hit;
        low_hit  = IN_LOW_1MB && sa_hit;

        io_wide_hit  = IO_WIDE && io_hit;
        mem_wide_hit = MEM_WIDE && la_hit;

        acc.rd_io  = io_hit && !ior_n;
        acc.wr_io  = io_hit && !iow_n;
        acc.rd_mem = (full_hit && !memr_n) || (low_hit && !smemr_n);
        acc.wr_mem = (full_hit && !memw_n) || (low_hit && !smemw_n);
        acc.zw_ok  = ZERO_WAIT && MEM_WIDE && !bus_aen && full_hit
                     && (!memr_n || !memw_n);
    end

endmodule

// File: rtl/isa_strobe_ctrl.sv
module isa_strobe_ctrl
    import isa_tgt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  bus_access_t acc,
    input  logic        io_wide_hit,
    input  logic        mem_wide_hit,
    output logic        iocs16_pull,
    output logic        memcs16_pull,
    output logic        dbus_oe,
    output logic        io_rd_pulse,
    output logic        io_wr_pulse,
    output logic        mem_rd_pulse,
    output logic        mem_wr_pulse
);

    typedef struct packed {
        logic       active;
        logic [3:0] sel;     // {io_rd, io_wr, mem_rd, mem_wr}
        logic       oe;
        logic       iocs;
        logic       memcs;
    } stb_regs_t;

    stb_regs_t r_d, r_q;
    logic any_acc;

    always_comb begin
        any_acc    = acc.rd_io || acc.wr_io || acc.rd_mem || acc.wr_mem;
        r_d        = r_q;
        r_d.active = any_acc;
        r_d.sel    = (any_acc && !r_q.active)
                     ? {acc.rd_io, acc.wr_io, acc.rd_mem, acc.wr_mem}
                     : 4'b0000;
        r_d.oe     = acc.rd_io || acc.rd_mem;
        r_d.iocs   = io_wide_hit;
        r_d.memcs  = mem_wide_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign iocs16_pull  = r_q.iocs;
    assign memcs16_pull = r_q.memcs;
    assign dbus_oe      = r_q.oe;
    assign io_rd_pulse  = r_q.sel[3];
    assign io_wr_pulse  = r_q.sel[2];
    assign mem_rd_pulse = r_q.sel[1];
    assign mem_wr_pulse = r_q.sel[0];

    // R2: at most one select per clock, each lasting a single clock
    a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_rd_pulse, io_wr_pulse, mem_rd_pulse, mem_wr_pulse}));
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd_pulse || io_wr_pulse || mem_rd_pulse || mem_wr_pulse)
        |=> !(io_rd_pulse || io_wr_pulse || mem_rd_pulse || mem_wr_pulse));
    // R12: data enable only follows a decoded read
    a_r12_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe |-> $past(acc.rd_io || acc.rd_mem));

endmodule

// File: rtl/isa_ready_ctrl.sv
module isa_ready_ctrl
    import isa_tgt_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_access_t       acc,
    input  logic              loc_ready,
    input  logic [WAIT_W-1:0] wait_limit,
    output logic              chrdy_pull,
    output logic              zws_pull
);

    localparam logic [WAIT_W-1:0] CNT_ZERO = '0;

    typedef struct packed {
        rdy_state_e        st;
        logic [WAIT_W-1:0] cnt;
        logic              chrdy;
        logic              zws;
    } rdy_regs_t;

    rdy_regs_t r_d, r_q;
    logic any_acc;

    always_comb begin
        any_acc   = acc.rd_io || acc.wr_io || acc.rd_mem || acc.wr_mem;
        r_d       = r_q;
        r_d.chrdy = 1'b0;
        r_d.zws   = 1'b0;
        if (!any_acc) begin
            r_d.st  = RDY_IDLE;
            r_d.cnt = CNT_ZERO;
        end else begin
            unique case (r_q.st)
                RDY_IDLE: begin
                    if (acc.zw_ok) begin
                        r_d.zws = 1'b1;
                        r_d.st  = RDY_HOLD;
                    end else if (!loc_ready && (wait_limit != CNT_ZERO)) begin
                        r_d.chrdy = 1'b1;
                        r_d.cnt   = wait_limit - 1'b1;
                        r_d.st    = RDY_WAIT;
                    end else begin
                        r_d.st = RDY_HOLD;
                    end
                end
                RDY_WAIT: begin
                    if (loc_ready || (r_q.cnt == CNT_ZERO)) begin
                        r_d.st = RDY_HOLD;
                    end else begin
                        r_d.chrdy = 1'b1;
                        r_d.cnt   = r_q.cnt - 1'b1;
                    end
                end
                RDY_HOLD: r_d.st = RDY_HOLD;
                default:  r_d.st = RDY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: RDY_IDLE, cnt: CNT_ZERO, chrdy: 1'b0, zws: 1'b0};
        else        r_q <= r_d;
    end

    assign chrdy_pull = r_q.chrdy;
    assign zws_pull   = r_q.zws;

    // R11: extension and early termination are exclusive
    a_r11_zws_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(zws_pull && chrdy_pull));
    // R9: early termination lasts one clock
    a_r9_zws_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        zws_pull |=> !zws_pull);
    // R7: sampled ready ends the extension
    a_r7_ready_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (chrdy_pull && loc_ready) |=> !chrdy_pull);
    // R13: extension needs an ongoing access
    a_r13_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        chrdy_pull |-> $past(any_acc));

endmodule

// File: rtl/isa_target_decoder.sv
module isa_target_decoder
    import isa_tgt_pkg::*;
#(
    parameter logic [15:0] IO_BASE   = 16'h0300,
    parameter logic [15:0] IO_MASK   = 16'hFFF0,
    parameter bit          IO_WIDE   = 1'b1,
    parameter logic [23:0] MEM_BASE  = 24'h0D0000,
    parameter logic [23:0] MEM_MASK  = 24'hFF0000,
    parameter bit          MEM_WIDE  = 1'b1,
    parameter bit          ZERO_WAIT = 1'b1,
    parameter int          WAIT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [19:0]       bus_sa,
    input  logic [6:0]        bus_la,
    input  logic              bus_aen,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic              smemr_n,
    input  logic              smemw_n,
    input  logic              memr_n,
    input  logic              memw_n,
    input  logic              loc_ready,
    input  logic [WAIT_W-1:0] wait_limit,
    output logic              iocs16_pull,
    output logic              memcs16_pull,
    output logic              chrdy_pull,
    output logic              zws_pull,
    output logic              dbus_oe,
    output logic              io_rd_pulse,
    output logic              io_wr_pulse,
    output logic              mem_rd_pulse,
    output logic              mem_wr_pulse
);

    bus_access_t acc;
    logic        io_wide_hit, mem_wide_hit;

    isa_addr_match #(
        .IO_BASE  (IO_BASE),
        .IO_MASK  (IO_MASK),
        .IO_WIDE  (IO_WIDE),
        .MEM_BASE (MEM_BASE),
        .MEM_MASK (MEM_MASK),
        .MEM_WIDE (MEM_WIDE),
        .ZERO_WAIT(ZERO_WAIT)
    ) u_match (
        .bus_sa      (bus_sa),
        .bus_la      (bus_la),
        .bus_aen     (bus_aen),
        .ior_n       (ior_n),
        .iow_n       (iow_n),
        .smemr_n     (smemr_n),
        .smemw_n     (smemw_n),
        .memr_n      (memr_n),
        .memw_n      (memw_n),
        .io_wide_hit (io_wide_hit),
        .mem_wide_hit(mem_wide_hit),
        .acc         (acc)
    );

    isa_strobe_ctrl u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc         (acc),
        .io_wide_hit (io_wide_hit),
        .mem_wide_hit(mem_wide_hit),
        .iocs16_pull (iocs16_pull),
        .memcs16_pull(memcs16_pull),
        .dbus_oe     (dbus_oe),
        .io_rd_pulse (io_rd_pulse),
        .io_wr_pulse (io_wr_pulse),
        .mem_rd_pulse(mem_rd_pulse),
        .mem_wr_pulse(mem_wr_pulse)
    );

    isa_ready_ctrl #(
        .WAIT_W(WAIT_W)
    ) u_ready (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .loc_ready (loc_ready),
        .wait_limit(wait_limit),
        .chrdy_pull(chrdy_pull),
        .zws_pull  (zws_pull)
    );

    // R10: early termination only after a memory command with AEN low
    a_r10_zws_mem_only: assert property (@(posedge clk) disable iff (!rst_n)
        zws_pull |-> $past(!bus_aen && (!memr_n || !memw_n)));
    // R8: a zero budget never extends
    a_r8_no_budget: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wait_limit) == '0 && $rose(chrdy_pull)) |-> 1'b0);

endmodule

// File: tb/isa_target_decoder_test.sv
`timescale 1ns/1ps
module isa_target_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_sa = '0;
    logic [6:0]  bus_la = '0;
    logic        bus_aen = 1'b0;
    logic        ior_n = 1'b1, iow_n = 1'b1, smemr_n = 1'b1, smemw_n = 1'b1;
    logic        memr_n = 1'b1, memw_n = 1'b1;
    logic        loc_ready = 1'b1;
    logic [3:0]  wait_limit = 4'd0;
    logic        iocs16_pull, memcs16_pull, chrdy_pull, zws_pull, dbus_oe;
    logic        io_rd_pulse, io_wr_pulse, mem_rd_pulse, mem_wr_pulse;

    // strobe codes {ior_n, iow_n, smemr_n, smemw_n, memr_n, memw_n}
    localparam logic [5:0] S_IDLE = 6'b111111;
    localparam logic [5:0] S_IOR  = 6'b011111;
    localparam logic [5:0] S_IOW  = 6'b101111;
    localparam logic [5:0] S_SMR  = 6'b110111;
    localparam logic [5:0] S_SMW  = 6'b111011;
    localparam logic [5:0] S_MR   = 6'b111101;
    localparam logic [5:0] S_MW   = 6'b111110;

    int n_vec = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    isa_target_decoder uut (
        .clk(clk), .rst_n(rst_n), .bus_sa(bus_sa), .bus_la(bus_la),
        .bus_aen(bus_aen), .ior_n(ior_n), .iow_n(iow_n), .smemr_n(smemr_n),
        .smemw_n(smemw_n), .memr_n(memr_n), .memw_n(memw_n),
        .loc_ready(loc_ready), .wait_limit(wait_limit),
        .iocs16_pull(iocs16_pull), .memcs16_pull(memcs16_pull),
        .chrdy_pull(chrdy_pull), .zws_pull(zws_pull), .dbus_oe(dbus_oe),
        .io_rd_pulse(io_rd_pulse), .io_wr_pulse(io_wr_pulse),
        .mem_rd_pulse(mem_rd_pulse), .mem_wr_pulse(mem_wr_pulse)
    );

    // order: iocs memcs chrdy zws oe io_rd io_wr mem_rd mem_wr
    function automatic logic [8:0] ev(bit ic, bit mc, bit ch, bit zw, bit oe,
                                      bit ir, bit iw, bit mr, bit mw);
        return {ic, mc, ch, zw, oe, ir, iw, mr, mw};
    endfunction

    function automatic logic [8:0] outs();
        return {iocs16_pull, memcs16_pull, chrdy_pull, zws_pull, dbus_oe,
                io_rd_pulse, io_wr_pulse, mem_rd_pulse, mem_wr_pulse};
    endfunction

    // driver: apply one clock of bus inputs, queue the expected response
    task automatic drive(input logic [19:0] sa, input logic [6:0] la,
                         input logic aen, input logic [5:0] stb,
                         input logic rdy, input logic [8:0] exp_v,
                         input string tag);
        bus_sa = sa; bus_la = la; bus_aen = aen; loc_ready = rdy;
        {ior_n, iow_n, smemr_n, smemw_n, memr_n, memw_n} = stb;
        exp_q.push_back(exp_v);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // monitor: compare one queued item per clock, just after the edge
    always begin
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) begin
            logic [8:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (outs() !== e) begin
                n_err++;
                $display("FAIL %s: got %b expected %b", t, outs(), e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        // R1: reset holds every output low even with a live I/O read
        bus_sa = 20'h00305; ior_n = 1'b0; loc_ready = 1'b0; wait_limit = 4'd3;
        repeat (3) @(negedge clk);
        n_vec++;
        if (outs() !== 9'b0) begin
            n_err++;
            $display("FAIL R1 reset: got %b expected %b", outs(), 9'b0);
        end
        ior_n = 1'b1;
        rst_n = 1'b1;

        // R2/R3/R12: I/O read, local ready
        wait_limit = 4'd3;
        drive(20'h00305, 7'h00, 0, S_IDLE, 1, ev(1,0,0,0,0,0,0,0,0), "R3 address only");
        drive(20'h00305, 7'h00, 0, S_IOR,  1, ev(1,0,0,0,1,1,0,0,0), "R2 io read start");
        drive(20'h00305, 7'h00, 0, S_IOR,  1, ev(1,0,0,0,1,0,0,0,0), "R12 io read held");
        drive(20'h00305, 7'h00, 0, S_IDLE, 1, ev(1,0,0,0,0,0,0,0,0), "R12 oe released");
        drive(20'h00000, 7'h00, 0, S_IDLE, 1, ev(0,0,0,0,0,0,0,0,0), "R3 address gone");

        // R6: full extension of 3 clocks
        drive(20'h00305, 7'h00, 0, S_IOW,  0, ev(1,0,1,0,0,0,1,0,0), "R6 ext 1");
        drive(20'h00305, 7'h00, 0, S_IOW,  0, ev(1,0,1,0,0,0,0,0,0), "R6 ext 2");
        drive(20'h00305, 7'h00, 0, S_IOW,  0, ev(1,0,1,0,0,0,0,0,0), "R6 ext 3");
        drive(20'h00305, 7'h00, 0, S_IOW,  0, ev(1,0,0,0,0,0,0,0,0), "R6 budget spent");
        drive(20'h00305, 7'h00, 0, S_IOW,  1, ev(1,0,0,0,0,0,0,0,0), "R6 stays released");
        drive(20'h00000, 7'h00, 0, S_IDLE, 1, ev(0,0,0,0,0,0,0,0,0), "R6 idle");

        // R7: early ready, no re-extension
        wait_limit = 4'd5;
        drive(20'h00305, 7'h00, 0, S_IOR,  0, ev(1,0,1,0,1,1,0,0,0), "R7 ext start");
        drive(20'h00305, 7'h00, 0, S_IOR,  0, ev(1,0,1,0,1,0,0,0,0), "R7 ext held");
        drive(20'h00305, 7'h00, 0, S_IOR,  1, ev(1,0,0,0,1,0,0,0,0), "R7 ready release");
        drive(20'h00305, 7'h00, 0, S_IOR,  0, ev(1,0,0,0,1,0,0,0,0), "R7 no re-extend");
        drive(20'h00000, 7'h00, 0, S_IDLE, 1, ev(0,0,0,0,0,0,0,0,0), "R7 idle");

        // R8: zero budget
        wait_limit = 4'd0;
        drive(20'h00305, 7'h00, 0, S_IOW,  0, ev(1,0,0,0,0,0,1,0,0), "R8 no extension");
        drive(20'h00305, 7'h00, 0, S_IOW,  0, ev(1,0,0,0,0,0,0,0,0), "R8 held");
        drive(20'h00000, 7'h00, 0, S_IDLE, 1, ev(0,0,0,0,0,0,0,0,0), "R8 idle");

        // R13: strobe ends mid-extension, then a fresh access
        wait_limit = 4'd5;
        drive(20'h00305, 7'h00, 0, S_IOW,  0, ev(1,0,1,0,0,0,1,0,0), "R13 ext start");
        drive(20'h00305, 7'h00, 0, S_IDLE, 0, ev(1,0,0,0,0,0,0,0,0), "R13 strobe ended");
        drive(20'h00305, 7'h00, 0, S_IOR,  1, ev(1,0,0,0,1,1,0,0,0), "R13 new access");
        drive(20'h00000, 7'h00, 0, S_IDLE, 1, ev(0,0,0,0,0,0,0,0,0), "R13 idle");

        // R2/R3: AEN high and outside addresses are ignored
        drive(20'h00305, 7'h00, 1, S_IOR,  1, ev(0,0,0,0,0,0,0,0,0), "R2 aen read ignored");
        drive(20'h00305, 7'h00, 1, S_IOW,  1, ev(0,0,0,0,0,0,0,0,0), "R2 aen write ignored");
        drive(20'h00310, 7'h00, 0, S_IOR,  1, ev(0,0,0,0,0,0,0,0,0), "R2 outside window");
        drive(20'h01305, 7'h00, 0, S_IOR,  1, ev(0,0,0,0,0,0,0,0,0), "R2 upper bits differ");
        drive(20'h00000, 7'h00, 0, S_IDLE, 1, ev(0,0,0,0,0,0,0,0,0), "R2 idle");

        // R9: zero-wait memory read and write, local not ready
        wait_limit = 4'd4;
        drive(20'hD1234, 7'h06, 0, S_MR,   0, ev(0,1,0,1,1,0,0,1,0), "R9 zws read");
        drive(20'hD1234, 7'h06, 0, S_MR,   0, ev(0,1,0,0,1,0,0,0,0), "R9 zws one clock");
        drive(20'hD1234, 7'h06, 0, S_MR,   0, ev(0,1,0,0,1,0,0,0,0), "R9 no extension");
        drive(20'hD1234, 7'h06, 0, S_IDLE, 0, ev(0,1,0,0,0,0,0,0,0), "R9 read end");
        drive(20'hD0002, 7'h06, 0, S_MW,   0, ev(0,1,0,1,0,0,0,0,1), "R9 zws write");
        drive(20'hD0002, 7'h06, 0, S_MW,   0, ev(0,1,0,0,0,0,0,0,0), "R9 write held");
        drive(20'h00000, 7'h00, 0, S_IDLE, 1, ev(0,0,0,0,0,0,0,0,0), "R9 idle");

        // R4/R5: size indication from LA only; full decode for memr
        drive(20'hC1234, 7'h06, 0, S_MR,   1, ev(0,1,0,0,0,0,0,0,0), "R5 sa outside");
        drive(20'h00000, 7'h06, 1, S_IDLE, 1, ev(0,1,0,0,0,0,0,0,0), "R4 la only, aen high");
        drive(20'hD1234, 7'h07, 0, S_MR,   1, ev(0,0,0,0,0,0,0,0,0), "R5 la outside");
        drive(20'h00000, 7'h00, 0, S_IDLE, 1, ev(0,0,0,0,0,0,0,0,0), "R5 idle");

        // R5/R10/R6: low-megabyte read ignores LA, takes the wait path
        wait_limit = 4'd2;
        drive(20'hD0010, 7'h00, 0, S_SMR,  0, ev(0,0,1,0,1,0,0,1,0), "R10 smem read ext");
        drive(20'hD0010, 7'h00, 0, S_SMR,  0, ev(0,0,1,0,1,0,0,0,0), "R6 smem ext 2");
        drive(20'hD0010, 7'h00, 0, S_SMR,  0, ev(0,0,0,0,1,0,0,0,0), "R6 smem budget spent");
        drive(20'h00000, 7'h00, 0, S_IDLE, 1, ev(0,0,0,0,0,0,0,0,0), "R12 smem end");
        drive(20'hC0000, 7'h00, 0, S_SMW,  0, ev(0,0,0,0,0,0,0,0,0), "R5 smem outside");
        drive(20'h00000, 7'h00, 0, S_IDLE, 1, ev(0,0,0,0,0,0,0,0,0), "R5 idle 2");

        // R10/R11: memory write with AEN high is extended, never zero-wait
        drive(20'hD0000, 7'h06, 1, S_MW,   0, ev(0,1,1,0,0,0,0,0,1), "R10 aen mem write");
        drive(20'hD0000, 7'h06, 1, S_MW,   0, ev(0,1,1,0,0,0,0,0,0), "R11 ext no zws");
        drive(20'hD0000, 7'h06, 1, S_MW,   0, ev(0,1,0,0,0,0,0,0,0), "R10 budget spent");
        drive(20'h00000, 7'h00, 0, S_IDLE, 1, ev(0,0,0,0,0,0,0,0,0), "R10 idle");

        wait (exp_q.size() == 0);
        @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule